// File: doc/BRIEF.md
# Four-Bank Busy Tracker and Read Router

This block sits between a host and a four-bank flash array. It watches every host write cycle and keeps a small state machine for each bank: idle, programming, erasing, erase-suspended, or programming while an erase is suspended. A separate per-bank flag records whether that bank is in the shortened unlock-bypass command mode. A read is steered with no added latency: when the addressed bank is busy, the host gets a status word; otherwise it gets the array data. This lets the host keep reading one bank while another bank runs an embedded program or erase.

The bank is picked from a three-bit field at the top of the host address. The split is uneven: the all-zeros value selects bank 0, the all-ones value selects bank 3, and the remaining values are shared between banks 1 and 2 according to the most significant bit. Command decoding is limited to counting cycles. The first write of a sequence carries an opcode byte. The last write starts the operation. Program data and sector addresses are not tracked.

The host side uses plain one-cycle strobes instead of a valid/ready pair. Every read is answered combinationally in the same cycle and every write is absorbed in one cycle, so the block never has a reason to hold the host off. `host_rd` and `host_wr` are not asserted together; if they are, the read is served and the write is dropped.

Top module: `bank_busy_router`

## Requirements
- R1: `bank_sel` is one-hot in the same cycle as the address, with `host_baddr` mapped as follows: 3'b000 selects bit 0; 3'b001 to 3'b011 select bit 1; 3'b100 to 3'b110 select bit 2; 3'b111 selects bit 3.
- R2: A read to a bank that is not busy drives `rd_data` = `array_rdata` and `status_sel` = 0 in the same cycle, even while another bank is busy.
- R3: A read to a busy bank drives `status_sel` = 1 and `rd_data` = status word in the same cycle, until that bank's completion. The status word has bits [2:0] = state code (1 program, 2 erase, 3 suspended, 4 program during suspend) and bit 3 = bypass flag, with all upper bits zero.
- R4: Outside bypass mode, an operation needs four writes to the same bank. The first write's `host_cmd` is the opcode (8'hA0 program, 8'h80 sector erase). The bank's `bank_busy` bit rises in the cycle after the fourth write.
- R5: Opcode 8'h20 in a four-write sequence puts the bank into bypass mode. In bypass mode a sequence takes two writes. Opcode 8'h90 leaves bypass mode.
- R6: Opcode 8'h10 (whole-device erase) sets all four `bank_busy` bits after its last write, but only if every bank is idle. Otherwise it is dropped and `wr_err` is raised.
- R7: An `op_done` pulse makes a programming or erasing bank idle, and makes a bank programming during a suspend return to the suspended state. The busy bit clears in the next cycle. A pulse to an idle or suspended bank has no effect.
- R8: A write of 8'hB0 to an erasing bank suspends it in the next cycle: the bank is no longer busy and reads return array data. A single write of 8'h30 to a suspended bank resumes the erase.
- R9: In a suspended bank, a program sequence (opcode 8'hA0) makes the bank busy with state code 4. Its completion returns the bank to the suspended state.
- R10: Any other write to a busy bank is ignored and raises `wr_err` for exactly the next cycle.
- R11: A read to a bank in the middle of a sequence restarts that bank's count. Reads to other banks do not. A first write whose opcode is not one of 8'hA0, 8'h80, 8'h10, 8'h20 or 8'h90 does not start a count.
- R12: Reset (asynchronous, active low) makes every bank idle and leaves bypass mode, with `bank_busy` = 0 and `wr_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_baddr | input | BA_W (3) | Bank field of the host address |
| host_cmd | input | 8 | Low byte of the host write data (opcode) |
| array_rdata | input | DATA_W (16) | Data read from the array for the current address |
| op_done | input | 4 | Per-bank completion pulse of an embedded operation |
| rd_data | output | DATA_W (16) | Routed read data: array data or status word |
| status_sel | output | 1 | High when `rd_data` carries the status word |
| bank_sel | output | 4 | One-hot decoded bank of the current address |
| bank_busy | output | 4 | Per-bank busy vector |
| wr_err | output | 1 | One-cycle flag for a rejected write |

## Verification
`bank_sel`, `status_sel` and `rd_data` are combinational, so their value is due in the same cycle as the read that produces it. The bench drives each vector just after a falling edge and samples these outputs 1 ns later, when they still reflect the state before the coming rising edge. `bank_busy` and `wr_err` are registered, so the effect of a write or a completion pulse is due one rising edge later. The bench samples them 2 ns after that edge, before the next vector is applied. Multi-write sequences are checked on every write, so a bank that turns busy one write early or one write late shows up as a mismatch.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  localparam int NBANK = 4;
  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_SUSP  = 3'd3,
    ST_SPROG = 3'd4
  } bank_st_e;

  localparam logic [CMD_W-1:0] OP_PROG    = 8'hA0;
  localparam logic [CMD_W-1:0] OP_SERASE  = 8'h80;
  localparam logic [CMD_W-1:0] OP_CERASE  = 8'h10;
  localparam logic [CMD_W-1:0] OP_BYP_ON  = 8'h20;
  localparam logic [CMD_W-1:0] OP_BYP_OFF = 8'h90;
  localparam logic [CMD_W-1:0] OP_SUSPEND = 8'hB0;
  localparam logic [CMD_W-1:0] OP_RESUME  = 8'h30;
endpackage

// File: rtl/bbr_bank_decode.sv
module bbr_bank_decode #(
  parameter int BA_W = 3
) (
  input  logic [BA_W-1:0]          baddr,
  output logic [bbr_pkg::NBANK-1:0] onehot
);
  // Uneven split: the extreme codes get their own bank, the rest is
  // halved by the top bit (R1).
  always_comb begin
    onehot = '0;
    if (baddr == '0)            onehot[0] = 1'b1;
    else if (&baddr)            onehot[3] = 1'b1;
    else if (!baddr[BA_W-1])    onehot[1] = 1'b1;
    else                        onehot[2] = 1'b1;
  end
endmodule

// File: rtl/bbr_bank_ctl.sv
module bbr_bank_ctl
  import bbr_pkg::*;
#(
  parameter int LONG_SEQ  = 4,
  parameter int SHORT_SEQ = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             rd,
  input  logic             wr,
  input  logic [CMD_W-1:0] cmd,
  input  logic             done,
  input  logic             chip_go,
  output bank_st_e         st,
  output logic             byp,
  output logic             busy,
  output logic             chip_req,
  output logic             err
);
  localparam int CNT_W = (LONG_SEQ > 2) ? $clog2(LONG_SEQ) : 1;
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_SEQ - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_SEQ - 1);

  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] op_q;
  logic [CNT_W-1:0] last_idx;
  logic             wr_hit, rd_hit, known, fire, suspend_ok;

  always_comb begin
    busy       = (st == ST_PROG) || (st == ST_ERASE) || (st == ST_SPROG);
    wr_hit     = sel && wr && !rd;
    rd_hit     = sel && rd;
    last_idx   = byp ? LAST_SHORT : LAST_LONG;
    known      = (cmd == OP_PROG) || (cmd == OP_SERASE) || (cmd == OP_CERASE) ||
                 (cmd == OP_BYP_ON) || (cmd == OP_BYP_OFF);
    fire       = wr_hit && !busy && (cnt != '0) && (cnt == last_idx);
    suspend_ok = (st == ST_ERASE) && (cmd == OP_SUSPEND);
    chip_req   = fire && (st == ST_IDLE) && (op_q == OP_CERASE);
    err        = wr_hit && busy && !suspend_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      byp  <= 1'b0;
      cnt  <= '0;
      op_q <= '0;
    end else if (chip_go) begin
      st  <= ST_ERASE;
      cnt <= '0;
    end else begin
      if (rd_hit) begin
        cnt <= '0;                          // interrupted sequence (R11)
      end else if (wr_hit) begin
        if (busy) begin
          if (suspend_ok) st <= ST_SUSP;    // R8, others rejected (R10)
        end else if (cnt == '0) begin
          if (st == ST_SUSP && cmd == OP_RESUME) begin
            st <= ST_ERASE;                 // R8
          end else if (known) begin
            op_q <= cmd;
            cnt  <= CNT_W'(1);
          end
        end else if (fire) begin
          cnt <= '0;
          if (st == ST_IDLE) begin
            case (op_q)
              OP_PROG:    st  <= ST_PROG;   // R4
              OP_SERASE:  st  <= ST_ERASE;
              OP_BYP_ON:  byp <= 1'b1;      // R5
              OP_BYP_OFF: byp <= 1'b0;
              default:    ;
            endcase
          end else if (st == ST_SUSP && op_q == OP_PROG) begin
            st <= ST_SPROG;                 // R9
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (done) begin
        case (st)
          ST_PROG, ST_ERASE: st <= ST_IDLE; // R7
          ST_SPROG:          st <= ST_SUSP;
          default:           ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bbr_read_route.sv
module bbr_read_route #(
  parameter int DATA_W = 16
) (
  input  logic                            rd,
  input  logic [bbr_pkg::NBANK-1:0]       bank_sel,
  input  logic [bbr_pkg::NBANK-1:0]       busy,
  input  logic [bbr_pkg::NBANK-1:0][2:0]  st_vec,
  input  logic [bbr_pkg::NBANK-1:0]       byp,
  input  logic [DATA_W-1:0]               array_rdata,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            status_sel
);
  logic [2:0] sst;
  logic       sbyp;

  always_comb begin
    sst  = '0;
    sbyp = 1'b0;
    for (int i = 0; i < bbr_pkg::NBANK; i++) begin
      if (bank_sel[i]) begin
        sst  = st_vec[i];
        sbyp = byp[i];
      end
    end
    status_sel = rd && ((bank_sel & busy) != '0);
    rd_data    = status_sel ? {{(DATA_W-4){1'b0}}, sbyp, sst} : array_rdata;
  end
endmodule

// File: rtl/bank_busy_router.sv
module bank_busy_router
  import bbr_pkg::*;
#(
  parameter int BA_W      = 3,
  parameter int DATA_W    = 16,
  parameter int LONG_SEQ  = 4,
  parameter int SHORT_SEQ = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [BA_W-1:0]   host_baddr,
  input  logic [CMD_W-1:0]  host_cmd,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic [NBANK-1:0]  op_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              status_sel,
  output logic [NBANK-1:0]  bank_sel,
  output logic [NBANK-1:0]  bank_busy,
  output logic              wr_err
);
  bank_st_e                st [NBANK];
  logic [NBANK-1:0][2:0]   st_vec;
  logic [NBANK-1:0]        byp, chip_req, err, idle;
  logic                    chip_go, chip_err;

  bbr_bank_decode #(.BA_W(BA_W)) u_dec (
    .baddr  (host_baddr),
    .onehot (bank_sel)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    bbr_bank_ctl #(.LONG_SEQ(LONG_SEQ), .SHORT_SEQ(SHORT_SEQ)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bank_sel[g]),
      .rd       (host_rd),
      .wr       (host_wr),
      .cmd      (host_cmd),
      .done     (op_done[g]),
      .chip_go  (chip_go),
      .st       (st[g]),
      .byp      (byp[g]),
      .busy     (bank_busy[g]),
      .chip_req (chip_req[g]),
      .err      (err[g])
    );
    assign st_vec[g] = st[g];
    assign idle[g]   = (st[g] == ST_IDLE);
  end

  // Whole-device erase only when every bank is idle (R6)
  assign chip_go  = (chip_req != '0) && (&idle);
  assign chip_err = (chip_req != '0) && !(&idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= (err != '0) || chip_err;
  end

  bbr_read_route #(.DATA_W(DATA_W)) u_route (
    .rd          (host_rd),
    .bank_sel    (bank_sel),
    .busy        (bank_busy),
    .st_vec      (st_vec),
    .byp         (byp),
    .array_rdata (array_rdata),
    .rd_data     (rd_data),
    .status_sel  (status_sel)
  );
endmodule

// File: rtl/bbr_checker.sv
module bbr_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rd,
  input logic              host_wr,
  input logic [7:0]        host_cmd,
  input logic [DATA_W-1:0] array_rdata,
  input logic [3:0]        op_done,
  input logic [DATA_W-1:0] rd_data,
  input logic              status_sel,
  input logic [3:0]        bank_sel,
  input logic [3:0]        bank_busy,
  input logic              wr_err
);
  logic [3:0] susp_now;
  assign susp_now = (host_wr && !host_rd && host_cmd == 8'hB0) ? bank_sel : 4'b0;

  assert_status_on_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && ((bank_sel & bank_busy) != 4'b0)) |-> status_sel);

  assert_status_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_sel |-> host_rd);

  assert_array_on_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && ((bank_sel & bank_busy) == 4'b0)) |-> (rd_data == array_rdata));

  assert_err_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(host_wr));

  assert_busy_drops_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(bank_busy) & ~bank_busy) & ~($past(op_done) | $past(susp_now))) == 4'b0));

  assert_busy_rises_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_busy & ~$past(bank_busy)) != 4'b0) |-> $past(host_wr));
endmodule

bind bank_busy_router bbr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_rd     (host_rd),
  .host_wr     (host_wr),
  .host_cmd    (host_cmd),
  .array_rdata (array_rdata),
  .op_done     (op_done),
  .rd_data     (rd_data),
  .status_sel  (status_sel),
  .bank_sel    (bank_sel),
  .bank_busy   (bank_busy),
  .wr_err      (wr_err)
);

// File: tb/bank_busy_router_tb.sv
module bank_busy_router_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [2:0]  host_baddr = 3'd0;
  logic [7:0]  host_cmd = 8'd0;
  logic [15:0] array_rdata;
  logic [3:0]  op_done = 4'd0;
  logic [15:0] rd_data;
  logic        status_sel, wr_err;
  logic [3:0]  bank_sel, bank_busy;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign array_rdata = 16'hA000 | {13'd0, host_baddr};

  bank_busy_router u_dut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_baddr(host_baddr), .host_cmd(host_cmd), .array_rdata(array_rdata),
    .op_done(op_done), .rd_data(rd_data), .status_sel(status_sel),
    .bank_sel(bank_sel), .bank_busy(bank_busy), .wr_err(wr_err)
  );

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [2:0]  a;
    logic [7:0]  cmd;
    logic [3:0]  done;
    logic        e_ss;
    logic [15:0] e_rd;
    logic [3:0]  e_busy;
    logic        e_err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 72;
  // rd wr a cmd done | status_sel rd_data busy err | requirement
  localparam vec_t VEC [NV] = '{
    '{1,0,0,8'h00,4'h0, 0,16'hA000,4'h0,0, 2},  // R2 idle read
    '{0,1,1,8'hA0,4'h0, 0,16'h0000,4'h0,0, 4},  // R4 program bank1 write 1
    '{0,1,3,8'h55,4'h0, 0,16'h0000,4'h0,0, 4},
    '{0,1,2,8'hAA,4'h0, 0,16'h0000,4'h0,0, 4},
    '{0,1,1,8'h12,4'h0, 0,16'h0000,4'h2,0, 4},  // R4 busy after 4th
    '{1,0,3,8'h00,4'h0, 1,16'h0001,4'h2,0, 3},  // R3 status of busy bank
    '{1,0,4,8'h00,4'h0, 0,16'hA004,4'h2,0, 2},  // R2 other bank reads array
    '{0,1,2,8'hB0,4'h0, 0,16'h0000,4'h2,1, 10}, // R10 suspend to programming bank
    '{1,0,1,8'h00,4'h0, 1,16'h0001,4'h2,0, 10}, // R10 state unchanged, err gone
    '{0,0,0,8'h00,4'h2, 0,16'h0000,4'h0,0, 7},  // R7 done
    '{0,0,0,8'h00,4'h4, 0,16'h0000,4'h0,0, 7},  // R7 done on idle bank
    '{1,0,1,8'h00,4'h0, 0,16'hA001,4'h0,0, 2},
    '{0,1,6,8'h80,4'h0, 0,16'h0000,4'h0,0, 11}, // R11 erase seq, interrupted
    '{0,1,5,8'h00,4'h0, 0,16'h0000,4'h0,0, 11},
    '{1,0,4,8'h00,4'h0, 0,16'hA004,4'h0,0, 11},
    '{0,1,6,8'h80,4'h0, 0,16'h0000,4'h0,0, 11},
    '{0,1,6,8'h00,4'h0, 0,16'h0000,4'h0,0, 11},
    '{1,0,0,8'h00,4'h0, 0,16'hA000,4'h0,0, 11}, // R11 other-bank read keeps count
    '{0,1,6,8'h00,4'h0, 0,16'h0000,4'h0,0, 11},
    '{0,1,6,8'h00,4'h0, 0,16'h0000,4'h4,0, 4},
    '{0,1,5,8'hB0,4'h0, 0,16'h0000,4'h0,0, 8},  // R8 suspend
    '{1,0,5,8'h00,4'h0, 0,16'hA005,4'h0,0, 8},
    '{0,0,0,8'h00,4'h4, 0,16'h0000,4'h0,0, 7},  // R7 done on suspended bank
    '{0,1,6,8'hA0,4'h0, 0,16'h0000,4'h0,0, 9},  // R9 program in suspend
    '{0,1,6,8'h00,4'h0, 0,16'h0000,4'h0,0, 9},
    '{0,1,6,8'h00,4'h0, 0,16'h0000,4'h0,0, 9},
    '{0,1,6,8'h00,4'h0, 0,16'h0000,4'h4,0, 9},
    '{1,0,6,8'h00,4'h0, 1,16'h0004,4'h4,0, 9},
    '{0,0,0,8'h00,4'h4, 0,16'h0000,4'h0,0, 9},
    '{1,0,6,8'h00,4'h0, 0,16'hA006,4'h0,0, 9},
    '{0,1,6,8'h30,4'h0, 0,16'h0000,4'h4,0, 8},  // R8 resume
    '{1,0,4,8'h00,4'h0, 1,16'h0002,4'h4,0, 8},
    '{0,0,0,8'h00,4'h4, 0,16'h0000,4'h0,0, 7},
    '{0,1,7,8'h20,4'h0, 0,16'h0000,4'h0,0, 5},  // R5 enter bypass
    '{0,1,7,8'h00,4'h0, 0,16'h0000,4'h0,0, 5},
    '{0,1,7,8'h00,4'h0, 0,16'h0000,4'h0,0, 5},
    '{0,1,7,8'h00,4'h0, 0,16'h0000,4'h0,0, 5},
    '{1,0,7,8'h00,4'h0, 0,16'hA007,4'h0,0, 5},
    '{0,1,7,8'hA0,4'h0, 0,16'h0000,4'h0,0, 5},
    '{0,1,7,8'h34,4'h0, 0,16'h0000,4'h8,0, 5},  // R5 two-write program
    '{1,0,7,8'h00,4'h0, 1,16'h0009,4'h8,0, 5},
    '{0,0,0,8'h00,4'h8, 0,16'h0000,4'h0,0, 7},
    '{0,1,0,8'h77,4'h0, 0,16'h0000,4'h0,0, 11}, // R11 unknown opcode
    '{0,1,0,8'hA0,4'h0, 0,16'h0000,4'h0,0, 11},
    '{0,1,0,8'h00,4'h0, 0,16'h0000,4'h0,0, 11},
    '{0,1,0,8'h00,4'h0, 0,16'h0000,4'h0,0, 11},
    '{0,1,0,8'h00,4'h0, 0,16'h0000,4'h1,0, 11},
    '{0,0,0,8'h00,4'h1, 0,16'h0000,4'h0,0, 7},
    '{0,1,0,8'h10,4'h0, 0,16'h0000,4'h0,0, 6},  // R6 whole-device erase
    '{0,1,0,8'h00,4'h0, 0,16'h0000,4'h0,0, 6},
    '{0,1,0,8'h00,4'h0, 0,16'h0000,4'h0,0, 6},
    '{0,1,0,8'h00,4'h0, 0,16'h0000,4'hF,0, 6},
    '{0,0,0,8'h00,4'hF, 0,16'h0000,4'h0,0, 7},
    '{0,1,1,8'hA0,4'h0, 0,16'h0000,4'h0,0, 6},  // R6 busy bank blocks erase
    '{0,1,1,8'h00,4'h0, 0,16'h0000,4'h0,0, 6},
    '{0,1,1,8'h00,4'h0, 0,16'h0000,4'h0,0, 6},
    '{0,1,1,8'h00,4'h0, 0,16'h0000,4'h2,0, 6},
    '{0,1,0,8'h10,4'h0, 0,16'h0000,4'h2,0, 6},
    '{0,1,0,8'h00,4'h0, 0,16'h0000,4'h2,0, 6},
    '{0,1,0,8'h00,4'h0, 0,16'h0000,4'h2,0, 6},
    '{0,1,0,8'h00,4'h0, 0,16'h0000,4'h2,1, 6},
    '{1,0,0,8'h00,4'h0, 0,16'hA000,4'h2,0, 6},
    '{0,0,0,8'h00,4'h2, 0,16'h0000,4'h0,0, 7},
    '{0,1,7,8'h90,4'h0, 0,16'h0000,4'h0,0, 5},  // R5 leave bypass
    '{0,1,7,8'h00,4'h0, 0,16'h0000,4'h0,0, 5},
    '{0,1,7,8'hA0,4'h0, 0,16'h0000,4'h0,0, 5},
    '{0,1,7,8'h00,4'h0, 0,16'h0000,4'h0,0, 5},
    '{0,1,7,8'h00,4'h0, 0,16'h0000,4'h0,0, 5},
    '{0,1,7,8'h00,4'h0, 0,16'h0000,4'h8,0, 5},
    '{1,0,7,8'h00,4'h0, 1,16'h0001,4'h8,0, 5},
    '{0,0,0,8'h00,4'h8, 0,16'h0000,4'h0,0, 7},
    '{1,0,3,8'h00,4'h0, 0,16'hA003,4'h0,0, 2}
  };

  function automatic logic [3:0] exp_sel(input logic [2:0] a);
    if (a == 3'd0)      return 4'b0001;
    else if (a == 3'd7) return 4'b1000;
    else if (a < 3'd4)  return 4'b0010;
    else                return 4'b0100;
  endfunction

  task automatic check(input int req, input string what, input logic [15:0] got,
                       input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic rd, input logic wr, input logic [2:0] a,
                       input logic [7:0] c, input logic [3:0] d);
    host_rd = rd; host_wr = wr; host_baddr = a; host_cmd = c; op_done = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(12, "busy in reset", {12'd0, bank_busy}, 16'h0);
    check(12, "err in reset", {15'd0, wr_err}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].rd, VEC[i].wr, VEC[i].a, VEC[i].cmd, VEC[i].done);
      #1;
      check(1, "bank_sel", {12'd0, bank_sel}, {12'd0, exp_sel(VEC[i].a)});
      check(int'(VEC[i].req), "status_sel", {15'd0, status_sel}, {15'd0, VEC[i].e_ss});
      if (VEC[i].rd) check(int'(VEC[i].req), "rd_data", rd_data, VEC[i].e_rd);
      @(posedge clk);
      #2;
      check(int'(VEC[i].req), "bank_busy", {12'd0, bank_busy}, {12'd0, VEC[i].e_busy});
      check(int'(VEC[i].req), "wr_err", {15'd0, wr_err}, {15'd0, VEC[i].e_err});
    end

    // R1 full decode sweep, same cycle
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      drive(1'b0, 1'b0, 3'(a), 8'h00, 4'h0);
      #1;
      check(1, "decode sweep", {12'd0, bank_sel}, {12'd0, exp_sel(3'(a))});
    end

    // R12 reset in the middle of an operation clears busy and bypass
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      drive(1'b0, 1'b1, 3'd7, (k == 0) ? 8'h20 : 8'h00, 4'h0);
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      drive(1'b0, 1'b1, 3'd7, (k == 0) ? 8'hA0 : 8'h00, 4'h0);
    end
    @(negedge clk);
    drive(1'b0, 1'b0, 3'd0, 8'h00, 4'h0);
    check(12, "busy before reset", {12'd0, bank_busy}, 16'h0008);
    rst_n = 1'b0;
    #1;
    check(12, "busy after async reset", {12'd0, bank_busy}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // after reset bypass is gone: two writes must not start a program
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      drive(1'b0, 1'b1, 3'd7, (k == 0) ? 8'hA0 : 8'h00, 4'h0);
    end
    @(negedge clk);
    drive(1'b0, 1'b0, 3'd0, 8'h00, 4'h0);
    check(12, "bypass cleared by reset", {12'd0, bank_busy}, 16'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule